// File: doc/BRIEF.md
# Two-Spine Clock Deskew Controller

This block is the digital control loop that evens out clock arrival between two clock spines. An external phase comparator samples both spines and produces a strobe with a flag that says whether spine A arrives after spine B. The controller turns each accepted sample into one correction of one step. The correction is applied to one of two tapped delay lines. Each line is made of two inverter stages, and each stage has a bank of switchable capacitive loads. The load-enable bits of each line come out as a thermometer code.

A correction always shortens the late spine when that is possible. It lengthens the early spine only when the late spine already has no loads enabled. Each decision passes through a three-stage pipeline before the control register moves. While a decision is in flight, new samples are dropped, so the loop cannot over-correct. A lock indication rises once the comparator flag has flipped on a programmable number of consecutive retired decisions. A saturation pulse reports a correction that could not be applied.

Top module: `spine_deskew_ctrl`

## Requirements
- R1: After reset both tap vectors hold code 8, which is 16'h00FF. `lock_o` and `sat_o` are low.
- R2: Code n, from 0 to 16, appears on a tap vector as bits [n-1:0] set and all other bits clear. Bits [7:0] load the first inverter stage and bits [15:8] load the second.
- R3: A sample is accepted at a rising edge where `phase_vld` and `enable` are high and no decision is in flight. Its correction shows on the tap vectors after the third rising edge that follows the accepting edge, and not before.
- R4: A retired decision changes exactly one tap vector by exactly one load, or changes nothing. The two vectors never change in the same cycle.
- R5: With `phase_a_late`=1, line A loses one load if its code is above 0. Otherwise line B gains one load. With `phase_a_late`=0 the mirror rule applies: line B loses one load if above 0, else line A gains one.
- R6: When a retired decision cannot move either line (the late line is at 0 and the other is at 16), both vectors hold. `sat_o` is high for exactly the one cycle after that retirement edge.
- R7: Samples that arrive at any of the three rising edges after an accepting edge are discarded. A new sample can be accepted from the fourth edge onward.
- R8: While `enable` is low, samples are ignored. A decision already in flight still retires.
- R9: `lock_o` is high when each of the last LOCK_RUN (default 4) retired decisions had a flag different from the decision before it. A retired decision that repeats the previous flag clears `lock_o` and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Permits new samples to be accepted |
| phase_vld | input | 1 | Phase comparator sample strobe |
| phase_a_late | input | 1 | 1: spine A arrives after spine B; 0: spine B is late |
| spine_a_taps | output | 16 | Thermometer load enables of the spine A delay line |
| spine_b_taps | output | 16 | Thermometer load enables of the spine B delay line |
| lock_o | output | 1 | Alternation-based lock indication |
| sat_o | output | 1 | One-cycle pulse when a correction could not be applied |

## Verification
On every cycle the assertions check four things: each tap register keeps a legal thermometer shape, no register moves by more than one load per cycle, the two lines never move together, and at most one decision is in flight. They also check that a saturation pulse never lasts two cycles and that lock rises only on a retirement edge. Only the bench scenarios can show the rest. That covers the exact three-edge latency and the choice of line under the fall-back rule, which the bench drives all the way to saturation. It also covers that dropped strobes really leave the codes alone, and that lock rises after the right number of alternations and falls on a repeat.

// File: rtl/skew_pkg.sv
package skew_pkg;

    typedef struct packed {
        logic vld;
        logic a_late;
    } decision_t;

    typedef struct packed {
        logic sat;
    } top_state_t;

endpackage

// File: rtl/skw_pipe.sv
module skw_pipe
    import skew_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      take,
    input  logic      a_late,
    output logic      busy,
    output decision_t retire
);

    decision_t [DEPTH-1:0] stage_d, stage_q;
    logic      [DEPTH-1:0] vld_bits;

    always_comb begin
        stage_d[0].vld    = take;
        stage_d[0].a_late = a_late;
        for (int i = 1; i < DEPTH; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_vld
            assign vld_bits[g] = stage_q[g].vld;
        end
    endgenerate

    assign busy   = |vld_bits;
    assign retire = stage_q[DEPTH-1];

    // R7: the hold-off keeps at most one decision in the pipeline
    assert_single_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vld_bits));

endmodule

// File: rtl/skw_therm.sv
module skw_therm #(
    parameter int TOTAL      = 16,
    parameter int RESET_CODE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [TOTAL-1:0] taps,
    output logic             empty,
    output logic             full
);

    localparam logic [TOTAL-1:0] RST_VEC = {TOTAL{1'b1}} >> (TOTAL - RESET_CODE);

    logic [TOTAL-1:0] taps_d, taps_q;

    always_comb begin
        taps_d = taps_q;
        if (inc && !full) begin
            taps_d = {taps_q[TOTAL-2:0], 1'b1};
        end else if (dec && !empty) begin
            taps_d = {1'b0, taps_q[TOTAL-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taps_q <= RST_VEC;
        end else begin
            taps_q <= taps_d;
        end
    end

    assign taps  = taps_q;
    assign empty = ~taps_q[0];
    assign full  = taps_q[TOTAL-1];

    // R2: register always holds contiguous low-order ones
    assert_therm_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (taps_q & (taps_q + 1'b1)) == '0);

    // R4: a line never moves by more than one load per cycle
    assert_one_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(taps_q ^ $past(taps_q)) <= 1);

endmodule

// File: rtl/skw_lock.sv
module skw_lock #(
    parameter int RUN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ret_valid,
    input  logic ret_a_late,
    output logic locked
);

    localparam int CW = $clog2(RUN + 1);

    typedef struct packed {
        logic          have_prev;
        logic          prev;
        logic [CW-1:0] run;
    } lock_state_t;

    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ret_valid) begin
            st_d.have_prev = 1'b1;
            st_d.prev      = ret_a_late;
            if (st_q.have_prev && (st_q.prev != ret_a_late)) begin
                if (st_q.run != CW'(RUN)) begin
                    st_d.run = st_q.run + 1'b1;
                end
            end else begin
                st_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = (st_q.run == CW'(RUN));

    // R9: lock can only appear on an edge where a decision retired
    assert_lock_on_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(ret_valid));

endmodule

// File: rtl/spine_deskew_ctrl.sv
module spine_deskew_ctrl
    import skew_pkg::*;
#(
    parameter int LOADS_PER_STAGE = 8,
    parameter int INV_STAGES      = 2,
    parameter int PIPE_DEPTH      = 3,
    parameter int LOCK_RUN        = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  enable,
    input  logic                                  phase_vld,
    input  logic                                  phase_a_late,
    output logic [LOADS_PER_STAGE*INV_STAGES-1:0] spine_a_taps,
    output logic [LOADS_PER_STAGE*INV_STAGES-1:0] spine_b_taps,
    output logic                                  lock_o,
    output logic                                  sat_o
);

    localparam int TOTAL    = LOADS_PER_STAGE * INV_STAGES;
    localparam int MID_CODE = TOTAL / 2;
    localparam int NLINES   = 2;

    logic             busy, take;
    decision_t        ret;
    logic [NLINES-1:0] inc, dec, empty, full;
    logic [TOTAL-1:0] taps [NLINES];
    top_state_t       st_d, st_q;

    assign take = phase_vld & enable & ~busy;

    skw_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .a_late (phase_a_late),
        .busy   (busy),
        .retire (ret)
    );

    // index 0 = spine A, index 1 = spine B
    always_comb begin
        inc    = '0;
        dec    = '0;
        st_d.sat = 1'b0;
        if (ret.vld) begin
            if (ret.a_late) begin
                if (!empty[0])     dec[0] = 1'b1;
                else if (!full[1]) inc[1] = 1'b1;
                else               st_d.sat = 1'b1;
            end else begin
                if (!empty[1])     dec[1] = 1'b1;
                else if (!full[0]) inc[0] = 1'b1;
                else               st_d.sat = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_line
            skw_therm #(.TOTAL(TOTAL), .RESET_CODE(MID_CODE)) u_line (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (inc[g]),
                .dec   (dec[g]),
                .taps  (taps[g]),
                .empty (empty[g]),
                .full  (full[g])
            );
        end
    endgenerate

    skw_lock #(.RUN(LOCK_RUN)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .ret_valid  (ret.vld),
        .ret_a_late (ret.a_late),
        .locked     (lock_o)
    );

    assign spine_a_taps = taps[0];
    assign spine_b_taps = taps[1];
    assign sat_o        = st_q.sat;

    // R4: the two lines never move in the same cycle
    assert_one_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !((spine_a_taps != $past(spine_a_taps)) && (spine_b_taps != $past(spine_b_taps))));

    // R6: saturation report lasts a single cycle
    assert_sat_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |=> !sat_o);

endmodule

// File: tb/sim_spine_deskew_ctrl.sv
module sim_spine_deskew_ctrl;

    localparam int PERIOD = 10;
    localparam int TOTAL  = 16;
    localparam int RUN    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, phase_vld = 1'b0, phase_a_late = 1'b0;
    logic [TOTAL-1:0] a_taps, b_taps;
    logic lock_o, sat_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    int  m_a = 8, m_b = 8;
    bit  m_vld [3];
    bit  m_dir [3];
    bit  m_have_prev = 0, m_prev = 0;
    int  m_run = 0;
    bit  m_sat = 0;

    always #(PERIOD/2) clk = ~clk;

    spine_deskew_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .phase_vld    (phase_vld),
        .phase_a_late (phase_a_late),
        .spine_a_taps (a_taps),
        .spine_b_taps (b_taps),
        .lock_o       (lock_o),
        .sat_o        (sat_o)
    );

    function automatic logic [TOTAL-1:0] therm_of(int n);
        if (n == 0) return '0;
        return {TOTAL{1'b1}} >> (TOTAL - n);
    endfunction

    task automatic check(string tag, string what, logic [TOTAL-1:0] act, logic [TOTAL-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // predict state after the next rising edge for the given inputs
    task automatic model_step(bit en, bit v, bit f);
        bit busy, acc;
        busy = m_vld[0] | m_vld[1] | m_vld[2];
        acc  = en & v & ~busy;
        m_sat = 0;
        if (m_vld[2]) begin
            if (m_dir[2]) begin
                if (m_a > 0) m_a--; else if (m_b < TOTAL) m_b++; else m_sat = 1;
            end else begin
                if (m_b > 0) m_b--; else if (m_a < TOTAL) m_a++; else m_sat = 1;
            end
            if (m_have_prev && (m_prev != m_dir[2])) begin
                if (m_run < RUN) m_run++;
            end else begin
                m_run = 0;
            end
            m_have_prev = 1;
            m_prev = m_dir[2];
        end
        m_vld[2] = m_vld[1]; m_dir[2] = m_dir[1];
        m_vld[1] = m_vld[0]; m_dir[1] = m_dir[0];
        m_vld[0] = acc;      m_dir[0] = f;
    endtask

    task automatic compare_all(string tag);
        check(tag, "spine A taps", a_taps, therm_of(m_a));
        check(tag, "spine B taps", b_taps, therm_of(m_b));
        check(tag, "lock", {15'b0, lock_o}, {15'b0, (m_run >= RUN)});
        check(tag, "sat", {15'b0, sat_o}, {15'b0, m_sat});
    endtask

    task automatic step(bit en, bit v, bit f, string tag);
        enable = en; phase_vld = v; phase_a_late = f;
        model_step(en, v, f);
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic decide(bit f, string tag);
        step(1, 1, f, tag);
        repeat (3) step(1, 0, 0, tag);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin m_vld[i] = 0; m_dir[i] = 0; end
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", "spine A taps", a_taps, 16'h00FF);
        check("R1", "spine B taps", b_taps, 16'h00FF);
        check("R1", "lock", {15'b0, lock_o}, 16'h0);
        check("R1", "sat", {15'b0, sat_o}, 16'h0);
        rst_n = 1'b1;

        // R3: single decision, A late, latency of three edges after acceptance
        step(1, 1, 1, "R3");
        step(1, 0, 0, "R3");
        step(1, 0, 0, "R3");
        check("R3", "A unchanged before third edge", a_taps, 16'h00FF);
        step(1, 0, 0, "R3");
        check("R3", "A after third edge", a_taps, 16'h007F);

        // R7: strobes during flight are dropped
        step(1, 1, 0, "R7");
        step(1, 1, 1, "R7");
        step(1, 1, 1, "R7");
        step(1, 1, 1, "R7");
        check("R7", "B after one decision only", b_taps, 16'h007F);
        check("R7", "A untouched by dropped strobes", a_taps, 16'h007F);
        // fourth edge accepts
        step(1, 1, 1, "R7");
        repeat (3) step(1, 0, 0, "R7");
        check("R7", "A after strobe at fourth edge", a_taps, 16'h003F);

        // R8: enable low ignores strobes
        repeat (6) step(0, 1, 1, "R8");
        check("R8", "A with enable low", a_taps, 16'h003F);
        // in-flight decision still retires after enable drops
        step(1, 1, 0, "R8");
        repeat (3) step(0, 1, 1, "R8");
        check("R8", "B retired with enable low", b_taps, 16'h003F);

        // R9: alternating flags produce lock, a repeat clears it
        for (int i = 0; i < RUN + 1; i++) decide(i % 2 == 0, "R9");
        check("R9", "lock after alternations", {15'b0, lock_o}, 16'h1);
        decide(m_prev, "R9");
        check("R9", "lock cleared by repeat", {15'b0, lock_o}, 16'h0);

        // R5 and R6: drive A to zero, then B to full, then saturate
        for (int i = 0; i < 2 * TOTAL + 2; i++) begin
            if (m_a == 0 && m_b == TOTAL) begin
                step(1, 1, 1, "R6");
                repeat (3) step(1, 0, 0, "R6");
            end else begin
                decide(1, "R5");
            end
        end
        check("R5", "A emptied", a_taps, 16'h0000);
        check("R5", "B filled", b_taps, 16'hFFFF);
        // R6: explicit saturation pulse timing
        step(1, 1, 1, "R6");
        step(1, 0, 0, "R6");
        step(1, 0, 0, "R6");
        check("R6", "no pulse before retire", {15'b0, sat_o}, 16'h0);
        step(1, 0, 0, "R6");
        check("R6", "pulse after retire", {15'b0, sat_o}, 16'h1);
        step(1, 0, 0, "R6");
        check("R6", "pulse ends", {15'b0, sat_o}, 16'h0);
        // R5 mirror: B late pulls B down from full
        decide(0, "R5");
        check("R5", "B lost one load", b_taps, 16'h7FFF);

        // R2 and R4: random stimulus, every cycle checked against the model
        for (int i = 0; i < 3000; i++) begin
            bit en, v, f;
            en = ($urandom % 8) != 0;
            v  = $urandom % 2;
            f  = (m_a > m_b) ? (($urandom % 4) != 0) : (($urandom % 4) == 0);
            step(en, v, f, (i % 2 == 0) ? "R2" : "R4");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule